// File: doc/BRIEF.md
# Masked First-Error Capture Unit

This block gathers eight error event lines from a memory-channel buffer and filters each through a software-writable mask. In every clock cycle the surviving (unmasked) events are the only ones that can affect anything: they are recorded in two sticky status registers and they drive the per-class consequence outputs. The first-error register takes a snapshot of whatever unmasked errors appear while it is empty. All errors in that cycle are latched together. While it holds anything, later errors collect in a separate next-error register. Software clears status bits by writing ones.

One error source lives inside the block: a frame watchdog. It counts frame ticks between sync commands and raises a training violation when the gap reaches a parameterized limit. Each error class has its own consequence. A training violation asks for a northbound alert, a log strobe and auto self-refresh entry. An over-temperature event latches a fatal shutdown. An unimplemented configuration access strobes config logging and tells the command path to drop that access.

Top module: `errcap_top`

## Requirements
- R1: After reset the mask register reads 0xF6 and both status registers read 0. Register addresses are: 0 mask, 1 first-error status, 2 next-error status. Address 3 reads 0.
- R2: A mask bit of 1 blocks its error from both status registers and from every consequence output. A mask write takes effect from the following clock edge, and changing the mask leaves already latched status bits unchanged.
- R3: The status and mask bit positions are: 0 sideband command CRC error, 1 unimplemented configuration address, 2 over-temperature, 3 clock training violation, 4 injected alert, 5 injected status-return error, 6 wrong write payload count, 7 write buffer overflow. Bit 3 of `evt_i` is ORed with the internal watchdog violation.
- R4: Read data bits 31:8 are always 0, and write data bits 31:8 have no effect.
- R5: First-error status bits are sticky. Writing 1 to a bit at address 1 clears it, and writing 0 leaves it unchanged.
- R6: The first-error register loads the unmasked errors only in a cycle where it is entirely zero. All errors of that cycle are loaded together.
- R7: Unmasked errors that occur while the first-error register is nonzero set bits in the next-error register (address 2). That register is sticky and is cleared by writing 1.
- R8: Suppose a clearing write and a new error hit the same status bit in the same cycle. If the bit was already set, it ends up 0. If the bit was clear, it ends up 1.
- R9: The watchdog raises a training violation on the LIMIT-th frame tick (default 84) that has no intervening sync command. Its count restarts on a sync command and after each violation. A sync command in the same cycle as a tick wins.
- R10: An unmasked training violation pulses `alert_req`, `log_en` and `selfref_req` high for exactly the one cycle after the error is sampled.
- R11: An unmasked over-temperature error sets `shutdown`, which then stays high until reset.
- R12: An unmasked unimplemented configuration address error pulses `cfg_log_en` and `drop_cmd` for the one cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Raw error events, one per status bit |
| frame_tick | input | 1 | One frame elapsed |
| sync_cmd | input | 1 | Sync command received |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| alert_req | output | 1 | Northbound alert request pulse |
| log_en | output | 1 | Training-violation log strobe |
| selfref_req | output | 1 | Auto self-refresh entry request pulse |
| cfg_log_en | output | 1 | Config-error log strobe |
| drop_cmd | output | 1 | Drop the offending config command |
| shutdown | output | 1 | Fatal shutdown, sticky until reset |

## Verification
The bench aims at the following corner cases:
- **Clears colliding with new errors on the same bit.** A design that gave clears blanket priority would lose a fresh error. One that gave errors blanket priority would never let software clear a repeating error.
- **Several errors in the cycle the first register fills.** A design that latched only one of them, or spilled the rest into next-error, would be caught.
- **A mask written in the same cycle as an error.** The error must still be judged by the old mask.
- **The watchdog at exactly the limit and a sync arriving on a tick.** These expose off-by-one counts and a wrong priority between restart and counting.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int NUM_ERR   = 8;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;

    typedef logic [NUM_ERR-1:0] err_vec_t;

    typedef enum int {
        E_CRC      = 0,
        E_CFG      = 1,
        E_TEMP     = 2,
        E_TRAIN    = 3,
        E_INJALRT  = 4,
        E_INJSTAT  = 5,
        E_PAYLOAD  = 6,
        E_WBUF     = 7
    } err_bit_e;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK  = 2'd0,
        A_FIRST = 2'd1,
        A_NEXT  = 2'd2,
        A_NONE  = 2'd3
    } reg_addr_e;

    localparam err_vec_t MASK_RESET = 8'hF6;

    typedef struct packed {
        logic alert;
        logic log;
        logic selfref;
        logic cfg_log;
        logic drop;
    } action_t;

    // Sticky merge: a set bit survives unless cleared; a clear bit takes
    // a new error (when capture is allowed) even if a clear targets it.
    function automatic err_vec_t sticky_merge(err_vec_t cur, err_vec_t clr,
                                              err_vec_t evt, logic cap);
        err_vec_t add;
        add = cap ? (evt & ~cur) : '0;
        return (cur & ~clr) | add;
    endfunction

endpackage

// File: rtl/errcap_watchdog.sv
module errcap_watchdog #(
    parameter int LIMIT = 84
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_tick,
    input  logic sync_cmd,
    output logic violation
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        violation = !sync_cmd && frame_tick && (cnt_q == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || sync_cmd || violation) begin
            cnt_q <= '0;
        end else if (frame_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: counter never reaches the limit itself
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(LIMIT));
    // R9: a sync command restarts the count
    a_r9_sync_restart: assert property (@(posedge clk) disable iff (rst)
        sync_cmd |=> cnt_q == '0);

endmodule

// File: rtl/errcap_status.sv
module errcap_status
    import errcap_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cap_en,
    input  err_vec_t evt,
    input  err_vec_t clr,
    output err_vec_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= sticky_merge(q, clr, evt, cap_en);
        end
    end

    // R5/R7: with no clear, no set bit is ever lost
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((q & $past(q)) == $past(q)));
    // R6: without capture and without clears the register holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && clr == '0) |=> $stable(q));
    // R8: an error on a clear bit is recorded despite a clearing write
    a_r8_new_wins: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ((evt & ~q) != '0)) |=> ((q & $past(evt & ~q)) == $past(evt & ~q)));

endmodule

// File: rtl/errcap_top.sv
module errcap_top
    import errcap_pkg::*;
#(
    parameter int LIMIT = 84
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  evt_i,
    input  logic        frame_tick,
    input  logic        sync_cmd,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        alert_req,
    output logic        log_en,
    output logic        selfref_req,
    output logic        cfg_log_en,
    output logic        drop_cmd,
    output logic        shutdown
);
    err_vec_t  mask_q, first_q, next_q, raw, eff, clr_first, clr_next;
    logic      wd_viol;
    action_t   act_d, act_q;
    logic      shut_q;
    reg_addr_e addr;

    assign addr = reg_addr_e'(reg_addr);

    errcap_watchdog #(.LIMIT(LIMIT)) u_wd (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .sync_cmd(sync_cmd), .violation(wd_viol)
    );

    always_comb begin
        raw          = evt_i;
        raw[E_TRAIN] = evt_i[E_TRAIN] | wd_viol;
        eff          = raw & ~mask_q;
        clr_first    = (reg_wr && addr == A_FIRST) ? reg_wdata[NUM_ERR-1:0] : '0;
        clr_next     = (reg_wr && addr == A_NEXT)  ? reg_wdata[NUM_ERR-1:0] : '0;
    end

    errcap_status u_first (
        .clk(clk), .rst(rst), .cap_en(first_q == '0),
        .evt(eff), .clr(clr_first), .q(first_q)
    );

    errcap_status u_next (
        .clk(clk), .rst(rst), .cap_en(first_q != '0),
        .evt(eff), .clr(clr_next), .q(next_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RESET;
        end else if (reg_wr && addr == A_MASK) begin
            mask_q <= reg_wdata[NUM_ERR-1:0];
        end
    end

    always_comb begin
        act_d.alert   = eff[E_TRAIN];
        act_d.log     = eff[E_TRAIN];
        act_d.selfref = eff[E_TRAIN];
        act_d.cfg_log = eff[E_CFG];
        act_d.drop    = eff[E_CFG];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            shut_q <= 1'b0;
        end else begin
            act_q  <= act_d;
            shut_q <= shut_q | eff[E_TEMP];
        end
    end

    assign alert_req   = act_q.alert;
    assign log_en      = act_q.log;
    assign selfref_req = act_q.selfref;
    assign cfg_log_en  = act_q.cfg_log;
    assign drop_cmd    = act_q.drop;
    assign shutdown    = shut_q;

    always_comb begin
        reg_rdata = '0;
        case (addr)
            A_MASK:  reg_rdata[NUM_ERR-1:0] = mask_q;
            A_FIRST: reg_rdata[NUM_ERR-1:0] = first_q;
            A_NEXT:  reg_rdata[NUM_ERR-1:0] = next_q;
            default: reg_rdata = '0;
        endcase
    end

    // R11: shutdown is sticky until reset
    a_r11_shutdown_sticky: assert property (@(posedge clk) disable iff (rst)
        shutdown |=> shutdown);
    // R4: reserved read bits are zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:8] == '0);
    // R2: a fully masked cycle with no writes leaves the first register alone
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((raw & ~mask_q) == '0 && !reg_wr) |=> (first_q == $past(first_q)));
    // R12: drop and config log strobes travel together
    a_r12_pair: assert property (@(posedge clk) disable iff (rst)
        drop_cmd == cfg_log_en);

endmodule

// File: tb/errcap_top_tb.sv
module errcap_top_tb;
    localparam int LIMIT = 84;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  evt_i;
    logic        frame_tick, sync_cmd, reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        alert_req, log_en, selfref_req, cfg_log_en, drop_cmd, shutdown;

    int n_checks = 0;
    int n_errs   = 0;

    // model state
    logic [7:0] m_mask, m_first, m_next;
    int         m_cnt;
    logic       m_shut, m_train, m_cfg;

    always #10 clk = ~clk;

    errcap_top #(.LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst(rst), .evt_i(evt_i), .frame_tick(frame_tick),
        .sync_cmd(sync_cmd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert_req(alert_req),
        .log_en(log_en), .selfref_req(selfref_req), .cfg_log_en(cfg_log_en),
        .drop_cmd(drop_cmd), .shutdown(shutdown)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return {24'h0, m_mask};
            2'd1: return {24'h0, m_first};
            2'd2: return {24'h0, m_next};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] merge(logic [7:0] cur, logic [7:0] clr,
                                         logic [7:0] e, logic cap);
        return (cur & ~clr) | (cap ? (e & ~cur) : 8'h0);
    endfunction

    task automatic check_all();
        chk("R1/R4/R5/R7 rdata", reg_rdata, model_read(reg_addr));
        chk("R10 alert_req", {31'h0, alert_req}, {31'h0, m_train});
        chk("R10 log_en", {31'h0, log_en}, {31'h0, m_train});
        chk("R10 selfref_req", {31'h0, selfref_req}, {31'h0, m_train});
        chk("R12 cfg_log_en", {31'h0, cfg_log_en}, {31'h0, m_cfg});
        chk("R12 drop_cmd", {31'h0, drop_cmd}, {31'h0, m_cfg});
        chk("R11 shutdown", {31'h0, shutdown}, {31'h0, m_shut});
    endtask

    // One cycle: check current outputs, drive new inputs, advance model.
    task automatic step(logic [7:0] ev, logic tk, logic sy, logic wr,
                        logic [1:0] a, logic [31:0] wd);
        logic       viol;
        logic [7:0] raw, eff, cf, cn;
        @(negedge clk);
        check_all();
        evt_i = ev; frame_tick = tk; sync_cmd = sy;
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        viol = 1'b0;
        if (sy) m_cnt = 0;
        else if (tk) begin
            if (m_cnt == LIMIT - 1) begin viol = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        raw = ev; raw[3] = ev[3] | viol;
        eff = raw & ~m_mask;
        cf = (wr && a == 2'd1) ? wd[7:0] : 8'h0;
        cn = (wr && a == 2'd2) ? wd[7:0] : 8'h0;
        m_next  = merge(m_next, cn, eff, m_first != 8'h0);
        m_first = merge(m_first, cf, eff, m_first == 8'h0);
        if (wr && a == 2'd0) m_mask = wd[7:0];
        m_train = eff[3];
        m_cfg   = eff[1];
        m_shut  = m_shut | eff[2];
    endtask

    task automatic idle(logic [1:0] a);
        step(8'h0, 1'b0, 1'b0, 1'b0, a, 32'h0);
    endtask

    initial begin
        #4_000_000;
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; evt_i = 0; frame_tick = 0; sync_cmd = 0;
        reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        m_mask = 8'hF6; m_first = 0; m_next = 0; m_cnt = 0;
        m_shut = 0; m_train = 0; m_cfg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset values at every address
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a);
            #1;
            chk("R1 reset read", reg_rdata, model_read(2'(a)));
        end
        reg_addr = 0;

        // R2: reset-masked over-temp must not register or shut down
        step(8'h04, 0, 0, 0, 2'd1, 0);
        idle(2'd1);
        // R2: unmask all with upper bits set (R4), error in same cycle uses old mask
        step(8'h04, 0, 0, 1, 2'd0, 32'hFFFF_FF00);
        idle(2'd0);
        // R6: several errors latched together, R3 bit positions
        step(8'h23, 0, 0, 0, 2'd1, 0);
        idle(2'd1);
        // R7: later errors go to next
        step(8'h84, 0, 0, 0, 2'd2, 0);
        idle(2'd2);
        // R8: clear collision on set bit (bit 7) and clear bit (bit 6)
        step(8'hC0, 0, 0, 1, 2'd2, 32'hC0);
        idle(2'd2);
        // R5: write 0 leaves, write 1 clears
        step(8'h00, 0, 0, 1, 2'd1, 32'h0);
        step(8'h00, 0, 0, 1, 2'd1, 32'hFF);
        idle(2'd1);
        // R2: masking does not clear latched bits
        step(8'h00, 0, 0, 1, 2'd0, 32'hFF);
        idle(2'd2);
        step(8'h00, 0, 0, 1, 2'd0, 32'h00);
        // R9: exact limit, sync on a tick restarts
        for (int i = 0; i < LIMIT - 1; i++) step(8'h0, 1, 0, 0, 2'd1, 0);
        step(8'h0, 1, 1, 0, 2'd1, 0);
        for (int i = 0; i < LIMIT; i++) step(8'h0, 1, 0, 0, 2'd1, 0);
        idle(2'd1);
        step(8'h0, 0, 0, 1, 2'd1, 32'hFF);
        for (int i = 0; i < LIMIT; i++) step(8'h0, 1, 0, 0, 2'd2, 0);
        idle(2'd2);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic [7:0] ev;
            logic wr;
            logic [1:0] a;
            logic [31:0] wd;
            ev = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            wr = ($urandom % 6 == 0);
            a  = 2'($urandom);
            wd = $urandom;
            if (a == 2'd0 && ($urandom % 2 == 0)) wd[7:0] = 8'h00;
            step(ev, 1'($urandom % 2), ($urandom % 300 == 0), wr, a, wd);
        end
        @(negedge clk);
        check_all();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule